// File: doc/BRIEF.md
# Byte Program Controller With Toggle Polling

This block writes a stream of bytes into an 8-bit parallel NOR flash, one address after another, starting at a given address. For every byte it first reads the stored contents. A byte that already holds the requested value is passed over with no command traffic. Any other byte gets the three-cycle unlock-and-program command, then the data write, and then status polling. Polling ends once two reads in a row return the same value, or once a fixed number of reads has been used up. The value read last is compared with the requested byte. A mismatch ends the transfer with a failure code. The code is chosen by bit 5 of the status read taken two reads before the final one.

A transfer begins with a one-cycle `start` in the idle state. That cycle supplies the start address and the byte count. A transfer that would run past the end of the device is refused before any flash access. Bytes arrive on a valid/ready stream. `done` and `error` hold their values until the next start. Once a failure occurs, no further bytes are taken. If a requested byte would need a stored 0 to become a 1, a sticky warning flag is set, and the byte is still programmed.

The controller is one state machine with eight states:
- `ST_IDLE`: takes `start` and moves to `ST_CHECK`.
- `ST_CHECK`: refuses an out-of-range transfer (to `ST_IDLE`), finishes at once on zero length (to `ST_IDLE`), or moves to `ST_FETCH`.
- `ST_FETCH`: waits for an input byte and moves to `ST_PRE_REQ`.
- `ST_PRE_REQ` and `ST_PRE_CAP`: read the stored byte. From there the byte is skipped (back to `ST_FETCH`, or to `ST_IDLE` on the last byte), or programming begins in `ST_UNLOCK`.
- `ST_UNLOCK`: issues four writes and moves to `ST_POLL_REQ`.
- `ST_POLL_REQ` and `ST_POLL_CAP`: alternate for each status read. They return to `ST_POLL_REQ` while the status is unsettled. Otherwise they advance to the next byte or to `ST_IDLE`, or stop with a failure in `ST_IDLE`.

Top module: `flash_byte_prog`

## Requirements
- R1: After reset `done`, `error`, `warn`, `busy`, `in_ready`, `fl_we` and `fl_re` are 0 and `err_code` is 0.
- R2: Each accepted byte is first read from its target address; if the stored value equals the byte, no flash write is issued and the next address is processed.
- R3: A byte that differs is programmed with exactly four writes in this order: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the byte to its target address.
- R4: If the requested byte has a 1 in a bit where the stored byte has a 0, `warn` is set and stays set until the next start; the byte is still programmed.
- R5: After the data write at least three status reads are made, and polling stops at the first read (third or later) that equals the read before it.
- R6: Polling never exceeds MAX_POLLS status reads per byte; after that many reads it stops even if the status still changes.
- R7: If the final status read differs from the requested byte, the transfer ends with `error`=1 and `done`=1. `err_code` is 3 when bit 5 of the read two before the final one is set, and 2 otherwise.
- R8: A transfer for which start address plus length exceeds 2^AW ends with `error`=1, `err_code`=1 and `done`=1, with no flash access and no byte accepted; a transfer ending exactly at the top address is allowed.
- R9: After a failure `in_ready` stays 0 and `error` stays 1 until the next start, which clears `error`, `err_code`, `warn` and `done`.
- R10: After the last byte of a successful transfer, or at once for a zero-length transfer, `done`=1 with `error`=0 and `err_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| start_addr | input | AW | First target address |
| xfer_len | input | AW+1 | Number of bytes in the transfer |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Controller takes the input byte this cycle |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data returns on fl_rdata the next cycle |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Transfer finished (held until next start) |
| error | output | 1 | Transfer failed (held until next start) |
| err_code | output | 2 | 0 none, 1 out of range, 2 verify mismatch, 3 device fault |
| warn | output | 1 | A 0-to-1 bit change was requested |

## Verification
Errors in the state machine show at the flash pins within the same byte. A wrong transition is seen as a fifth write, a missing unlock write, or a read count after the data write that differs from the one set by the flash's busy length. A fault in the status history or the poll counter shows up a few reads later. It appears as polling that stops one read early or late, that runs past the cap, or that gives the wrong failure code. A fault in the sticky flags shows up as `in_ready` rising after a failure, or `warn` and `error` surviving a new start.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_PRE_REQ,
        ST_PRE_CAP,
        ST_UNLOCK,
        ST_POLL_REQ,
        ST_POLL_CAP
    } fbp_state_e;

    typedef enum logic [1:0] {
        FAULT_NONE   = 2'd0,
        FAULT_RANGE  = 2'd1,
        FAULT_VERIFY = 2'd2,
        FAULT_DEVICE = 2'd3
    } fbp_fault_e;

    localparam int unsigned UNLOCK_STEPS = 4;
    localparam int unsigned MIN_POLLS    = 3;
    localparam int unsigned HIST_ENTRIES = 4;
    localparam int unsigned KEY_ADDR_A   = 32'h555;
    localparam int unsigned KEY_ADDR_B   = 32'h2AA;
    localparam logic [7:0]  KEY_BYTE_A   = 8'hAA;
    localparam logic [7:0]  KEY_BYTE_B   = 8'h55;
    localparam logic [7:0]  PROG_BYTE    = 8'hA0;
    localparam int unsigned FAULT_BIT    = 5;
endpackage

// File: rtl/fbp_range_chk.sv
module fbp_range_chk #(
    parameter int unsigned AW = 11,
    parameter int unsigned LW = AW + 1
) (
    input  logic [AW-1:0] base_addr,
    input  logic [LW-1:0] length,
    output logic          overrun
);
    localparam int unsigned SW = ((AW > LW) ? AW : LW) + 2;
    localparam logic [SW-1:0] DEV_BYTES = SW'(1) << AW;

    logic [SW-1:0] end_excl;

    always_comb begin
        end_excl = SW'(base_addr) + SW'(length);
        overrun  = (end_excl > DEV_BYTES);
    end
endmodule

// File: rtl/fbp_cmd_gen.sv
module fbp_cmd_gen
    import fbp_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic [1:0]    step,
    input  logic [AW-1:0] target,
    input  logic [7:0]    payload,
    output logic [AW-1:0] cmd_addr,
    output logic [7:0]    cmd_data
);
    always_comb begin
        unique case (step)
            2'd0: begin
                cmd_addr = AW'(KEY_ADDR_A);
                cmd_data = KEY_BYTE_A;
            end
            2'd1: begin
                cmd_addr = AW'(KEY_ADDR_B);
                cmd_data = KEY_BYTE_B;
            end
            2'd2: begin
                cmd_addr = AW'(KEY_ADDR_A);
                cmd_data = PROG_BYTE;
            end
            default: begin
                cmd_addr = target;
                cmd_data = payload;
            end
        endcase
    end
endmodule

// File: rtl/fbp_poll_hist.sv
module fbp_poll_hist #(
    parameter int unsigned ENTRIES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       push,
    input  logic [7:0] sample,
    output logic [7:0] prev_q,
    output logic [7:0] back2_q
);
    localparam int unsigned IW = $clog2(ENTRIES);

    logic [IW-1:0]              wr_idx;
    logic [ENTRIES-1:0][7:0]    slots;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
        end else if (clear) begin
            wr_idx <= '0;
        end else if (push) begin
            wr_idx <= wr_idx + IW'(1);
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [7:0] entry_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (push && (wr_idx == IW'(g))) begin
                entry_q <= sample;
            end
        end
        assign slots[g] = entry_q;
    end

    assign prev_q  = slots[wr_idx - IW'(1)];
    assign back2_q = slots[wr_idx - IW'(2)];
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
    import fbp_pkg::*;
#(
    parameter int unsigned AW        = 11,
    parameter int unsigned MAX_POLLS = 10000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW:0]     xfer_len,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic [AW-1:0]   fl_addr,
    output logic [7:0]      fl_wdata,
    output logic            fl_we,
    output logic            fl_re,
    input  logic [7:0]      fl_rdata,
    output logic            busy,
    output logic            done,
    output logic            error,
    output logic [1:0]      err_code,
    output logic            warn
);
    localparam int unsigned LW  = AW + 1;
    localparam int unsigned PCW = $clog2(MAX_POLLS + 1);
    localparam logic [PCW-1:0] POLL_LIMIT = PCW'(MAX_POLLS);
    localparam logic [PCW-1:0] POLL_FLOOR = PCW'(MIN_POLLS);
    localparam logic [1:0]     LAST_STEP  = 2'(UNLOCK_STEPS - 1);

    fbp_state_e state_q, state_nx;

    logic [AW-1:0]  addr_q;
    logic [LW-1:0]  remain_q;
    logic [7:0]     data_q;
    logic [1:0]     step_q;
    logic [PCW-1:0] poll_q;
    logic           done_q, error_q, warn_q;
    fbp_fault_e     code_q;

    logic           overrun;
    logic [AW-1:0]  cmd_addr;
    logic [7:0]     cmd_data;
    logic [7:0]     hist_prev, hist_back2;
    logic [PCW-1:0] poll_next;
    logic           poll_stop, verify_ok, last_byte, pre_match, raise_warn;

    fbp_range_chk #(.AW(AW), .LW(LW)) u_range (
        .base_addr (addr_q),
        .length    (remain_q),
        .overrun   (overrun)
    );

    fbp_cmd_gen #(.AW(AW)) u_cmd (
        .step     (step_q),
        .target   (addr_q),
        .payload  (data_q),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    fbp_poll_hist #(.ENTRIES(HIST_ENTRIES)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_UNLOCK),
        .push    (state_q == ST_POLL_CAP),
        .sample  (fl_rdata),
        .prev_q  (hist_prev),
        .back2_q (hist_back2)
    );

    // Decisions taken on the byte returned by the flash this cycle.
    always_comb begin
        poll_next  = poll_q + PCW'(1);
        poll_stop  = ((poll_next >= POLL_FLOOR) && (fl_rdata == hist_prev)) ||
                     (poll_next >= POLL_LIMIT);
        verify_ok  = (fl_rdata == data_q);
        pre_match  = (fl_rdata == data_q);
        raise_warn = ((~fl_rdata & data_q) != 8'h00);
        last_byte  = (remain_q == LW'(1));
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (overrun || (remain_q == '0)) state_nx = ST_IDLE;
                else                             state_nx = ST_FETCH;
            end
            ST_FETCH:    if (in_valid) state_nx = ST_PRE_REQ;
            ST_PRE_REQ:  state_nx = ST_PRE_CAP;
            ST_PRE_CAP: begin
                if (!pre_match)     state_nx = ST_UNLOCK;
                else if (last_byte) state_nx = ST_IDLE;
                else                state_nx = ST_FETCH;
            end
            ST_UNLOCK:   if (step_q == LAST_STEP) state_nx = ST_POLL_REQ;
            ST_POLL_REQ: state_nx = ST_POLL_CAP;
            ST_POLL_CAP: begin
                if (!poll_stop)                   state_nx = ST_POLL_REQ;
                else if (!verify_ok || last_byte) state_nx = ST_IDLE;
                else                              state_nx = ST_FETCH;
            end
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Datapath and sticky result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            data_q   <= '0;
            step_q   <= '0;
            poll_q   <= '0;
            done_q   <= 1'b0;
            error_q  <= 1'b0;
            warn_q   <= 1'b0;
            code_q   <= FAULT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q   <= start_addr;
                        remain_q <= xfer_len;
                        done_q   <= 1'b0;
                        error_q  <= 1'b0;
                        warn_q   <= 1'b0;
                        code_q   <= FAULT_NONE;
                    end
                end
                ST_CHECK: begin
                    if (overrun) begin
                        error_q <= 1'b1;
                        code_q  <= FAULT_RANGE;
                        done_q  <= 1'b1;
                    end else if (remain_q == '0) begin
                        done_q  <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (in_valid) data_q <= in_data;
                end
                ST_PRE_CAP: begin
                    step_q <= '0;
                    if (pre_match) begin
                        addr_q   <= addr_q + AW'(1);
                        remain_q <= remain_q - LW'(1);
                        if (last_byte) done_q <= 1'b1;
                    end else if (raise_warn) begin
                        warn_q <= 1'b1;
                    end
                end
                ST_UNLOCK: begin
                    step_q <= step_q + 2'd1;
                    poll_q <= '0;
                end
                ST_POLL_CAP: begin
                    poll_q <= poll_next;
                    if (poll_stop) begin
                        if (!verify_ok) begin
                            error_q <= 1'b1;
                            done_q  <= 1'b1;
                            code_q  <= hist_back2[FAULT_BIT] ? FAULT_DEVICE : FAULT_VERIFY;
                        end else begin
                            addr_q   <= addr_q + AW'(1);
                            remain_q <= remain_q - LW'(1);
                            if (last_byte) done_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = addr_q;
        fl_wdata = 8'h00;
        busy     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_FETCH:    in_ready = 1'b1;
            ST_PRE_REQ:  fl_re    = 1'b1;
            ST_POLL_REQ: fl_re    = 1'b1;
            ST_UNLOCK: begin
                fl_we    = 1'b1;
                fl_addr  = cmd_addr;
                fl_wdata = cmd_data;
            end
            default: ;
        endcase
        done     = done_q;
        error    = error_q;
        err_code = code_q;
        warn     = warn_q;
    end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
    parameter int unsigned AW        = 11,
    parameter int unsigned MAX_POLLS = 10000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic [AW:0]   xfer_len,
    input logic          in_valid,
    input logic          in_ready,
    input logic          fl_we,
    input logic          fl_re,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [1:0]    err_code,
    input logic          warn
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 2) + 1;
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
    localparam logic [AW+1:0] DEV_BYTES = (AW+2)'(1) << AW;

    logic [CW-1:0] reads_since;
    logic          over_req;

    assign over_req = (({2'b00, start_addr} + {1'b0, xfer_len}) > DEV_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reads_since <= '0;
        end else if (fl_we || (in_valid && in_ready)) begin
            reads_since <= '0;
        end else if (fl_re && (reads_since != CNT_TOP)) begin
            reads_since <= reads_since + CW'(1);
        end
    end

    // R6: no more than MAX_POLLS reads follow a data write
    assert_poll_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reads_since <= CW'(MAX_POLLS));

    // R9: no byte accepted while a failure is held
    assert_no_accept_after_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !in_ready);

    // R8: an overrunning request fails with the range code two cycles later
    assert_range_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && over_req) |=> ##1 (error && (err_code == 2'd1) && done));

    // R3: write and read strobes never together
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_we, fl_re}));

    // R4: warn only clears on a start
    assert_warn_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn) |-> $past(start));

    // R7: a failure is always reported together with completion
    assert_fail_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
endmodule

bind flash_byte_prog fbp_checker #(.AW(AW), .MAX_POLLS(MAX_POLLS)) u_fbp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .xfer_len   (xfer_len),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .err_code   (err_code),
    .warn       (warn)
);

// File: tb/tb_flash_byte_prog.sv
module tb_flash_byte_prog;
    localparam int AW     = 11;
    localparam int MAXP   = 40;
    localparam int CLK_NS = 10;
    localparam int DEV    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW:0]   xfer_len = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_we, fl_re;
    logic [7:0]    fl_rdata = '0;
    logic          busy, done, error, warn;
    logic [1:0]    err_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_byte_prog #(.AW(AW), .MAX_POLLS(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .xfer_len(xfer_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .busy(busy),
        .done(done), .error(error), .err_code(err_code), .warn(warn)
    );

    // Flash model
    logic [7:0] mem [DEV];
    int  ulk = 0;
    int  busy_left = 0;
    logic tog = 1'b0;
    logic [7:0] pdata = '0;
    int  rd_total = 0, wr_total = 0, polls = 0, seq_bad = 0;
    int  m_busy = 0;
    bit  m_sticky = 0, m_f5 = 0, m_noprog = 0;

    always @(posedge clk) begin
        if (fl_we) begin
            wr_total <= wr_total + 1;
            case (ulk)
                0: ulk <= (fl_addr == 11'h555 && fl_wdata == 8'hAA) ? 1 : 0;
                1: ulk <= (fl_addr == 11'h2AA && fl_wdata == 8'h55) ? 2 : 0;
                2: ulk <= (fl_addr == 11'h555 && fl_wdata == 8'hA0) ? 3 : 0;
                default: begin
                    ulk <= 0;
                    if (!m_noprog) mem[fl_addr] <= mem[fl_addr] & fl_wdata;
                    pdata     <= fl_wdata;
                    busy_left <= m_sticky ? 1000000 : m_busy;
                    tog       <= 1'b0;
                    polls     <= 0;
                end
            endcase
            if (ulk == 0 && !(fl_addr == 11'h555 && fl_wdata == 8'hAA)) seq_bad <= seq_bad + 1;
        end
        if (fl_re) begin
            rd_total <= rd_total + 1;
            polls    <= polls + 1;
            if (busy_left > 0) begin
                fl_rdata  <= {~pdata[7], tog, m_f5, 5'b0};
                tog       <= ~tog;
                busy_left <= busy_left - 1;
            end else begin
                fl_rdata <= mem[fl_addr];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic model_cfg(input int b, input bit st, input bit f5, input bit np);
        m_busy = b; m_sticky = st; m_f5 = f5; m_noprog = np;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        rd_total = 0; wr_total = 0; polls = 0; seq_bad = 0;
    endtask

    task automatic pulse_start(input int a, input int n);
        @(negedge clk);
        start = 1'b1; start_addr = AW'(a); xfer_len = (AW+1)'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        int w = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        while (!in_ready && !done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (in_ready) @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic t_reset();
        check(!done && !error && !warn && !busy && !in_ready && !fl_we && !fl_re &&
              err_code == 2'd0, "R1", "reset outputs",
              {done, error, warn, busy, in_ready, fl_we, fl_re}, 0);
    endtask

    task automatic t_program();
        mem[11'h100] = 8'hFF; mem[11'h101] = 8'hFF; mem[11'h102] = 8'hFF;
        model_cfg(5, 0, 0, 0);
        clear_counts();
        pulse_start(11'h100, 3);
        send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h00);
        wait_done();
        check(mem[11'h100] == 8'hA5 && mem[11'h101] == 8'h3C && mem[11'h102] == 8'h00,
              "R3", "programmed contents", mem[11'h101], 8'h3C);
        check(wr_total == 12 && seq_bad == 0, "R3", "write count", wr_total, 12);
        check(rd_total == 24, "R5", "reads with busy of 5", rd_total, 24);
        check(done && !error && err_code == 0 && !warn, "R10", "done clean", error, 0);
    endtask

    task automatic t_min_poll();
        mem[11'h300] = 8'hFF;
        model_cfg(0, 0, 0, 0);
        clear_counts();
        pulse_start(11'h300, 1);
        send_byte(8'h81);
        wait_done();
        check(polls == 3, "R5", "minimum status reads", polls, 3);
        check(mem[11'h300] == 8'h81 && !error, "R5", "min poll result", mem[11'h300], 8'h81);
    endtask

    task automatic t_skip();
        mem[11'h200] = 8'h11; mem[11'h201] = 8'h22;
        model_cfg(3, 0, 0, 0);
        clear_counts();
        pulse_start(11'h200, 2);
        send_byte(8'h11); send_byte(8'h22);
        wait_done();
        check(wr_total == 0, "R2", "skip writes", wr_total, 0);
        check(rd_total == 2 && done && !error, "R2", "skip reads", rd_total, 2);
    endtask

    task automatic t_warn();
        mem[11'h050] = 8'h0F;
        model_cfg(2, 0, 0, 0);
        clear_counts();
        pulse_start(11'h050, 1);
        send_byte(8'hF0);
        wait_done();
        check(warn == 1'b1, "R4", "warn set", warn, 1);
        check(wr_total == 4, "R4", "still programmed", wr_total, 4);
        check(error && err_code == 2'd2, "R7", "verify code", err_code, 2);
    endtask

    task automatic t_device_and_hold();
        bit leaked = 0;
        mem[11'h060] = 8'hFF;
        model_cfg(4, 0, 1, 1);
        clear_counts();
        pulse_start(11'h060, 2);
        send_byte(8'h12);
        wait_done();
        check(error && err_code == 2'd3, "R7", "device code", err_code, 3);
        check(polls == 6, "R5", "polls before steady fault", polls, 6);
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h77;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (in_ready || !error) leaked = 1;
        end
        in_valid = 1'b0;
        check(!leaked && wr_total == 4, "R9", "held after failure", leaked, 0);
        mem[11'h070] = 8'h44;
        model_cfg(0, 0, 0, 0);
        pulse_start(11'h070, 1);
        check(!error && !warn && !done && err_code == 0, "R9", "start clears", error, 0);
        send_byte(8'h44);
        wait_done();
    endtask

    task automatic t_timeout();
        mem[11'h080] = 8'hFF;
        model_cfg(0, 1, 0, 0);
        clear_counts();
        pulse_start(11'h080, 1);
        send_byte(8'h33);
        wait_done();
        check(polls == MAXP, "R6", "poll cap", polls, MAXP);
        check(error && err_code == 2'd2, "R6", "timeout verdict", err_code, 2);
        model_cfg(0, 0, 0, 0);
        @(negedge clk);
        busy_left = 0;
    endtask

    task automatic t_range();
        clear_counts();
        pulse_start(2040, 9);
        wait_done();
        check(error && err_code == 2'd1 && done, "R8", "overrun code", err_code, 1);
        check(rd_total == 0 && wr_total == 0 && !in_ready, "R8", "no access", rd_total, 0);
        mem[2047] = 8'hFF;
        model_cfg(1, 0, 0, 0);
        clear_counts();
        pulse_start(2047, 1);
        send_byte(8'h5A);
        wait_done();
        check(!error && mem[2047] == 8'h5A && polls == 3, "R8", "top boundary", mem[2047], 8'h5A);
    endtask

    task automatic t_zero_len();
        clear_counts();
        pulse_start(11'h010, 0);
        wait_done();
        check(done && !error && rd_total == 0 && wr_total == 0, "R10", "zero length",
              rd_total + wr_total, 0);
    endtask

    initial begin
        for (int i = 0; i < DEV; i++) mem[i] = 8'hFF;
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_min_poll();
        t_skip();
        t_warn();
        t_device_and_hold();
        t_timeout();
        t_range();
        t_zero_len();
        finish_run();
    end
endmodule